// File: doc/BRIEF.md
# DMA Write Window Guard

This block sits on the write path between the chipset's memory masters (the blitter, the display-list coprocessor and disk DMA) and shared memory. It holds one protected address window and a legacy-mode enable. While legacy mode is on, any master write whose address range touches the window is kept away from memory. Instead, a violation interrupt is raised to the host CPU so that the operating system can take over. This keeps a second operating system's memory and display buffer safe from a legacy system that still drives the chipset directly.

The window check is pure combinational logic that runs alongside the request. Permitted writes go to the memory side in the same cycle they arrive, with no added pipeline stage. A refused write is still handed a grant, so the DMA engine that issued it moves on and does not wait forever. The bounds and the mode bit are set through a small register port. The first offending address and the master ID that issued it are held until software clears the interrupt.

Top module: `dma_window_guard`

## Requirements
- R1: While the legacy-mode bit (register select 0, data bit 0) is 0, every master request is forwarded to memory (`mem_req` equals `m_req`) in the same cycle.
- R2: While legacy mode is 1, a single-beat write whose address lies in the window never asserts `mem_req`.
- R3: The window contains the lower bound (select 1) and excludes the upper bound (select 2). An address equal to the lower bound is refused. An address equal to the upper bound passes, and so does the address one below the lower bound.
- R4: When the lower bound is greater than or equal to the upper bound, the window is empty and no write is refused.
- R5: A burst covers `m_addr` through `m_addr + m_len`. It is refused as a whole if any beat in that range is inside the window, and it passes if every beat is outside.
- R6: A forwarded request carries the same address, length, ID, data and read/write flag to the memory side in the same cycle.
- R7: `m_grant` follows `m_req & mem_rdy` for both forwarded and refused requests. A refused request is granted in the same cycle that a forwarded one would be.
- R8: A refused write that is granted sets `viol_irq` on the next clock edge and loads `viol_addr` and `viol_id`. While `viol_irq` is set, later violations do not change the stored address or ID.
- R9: A register write to select 3 with data bit 0 equal to 1 clears `viol_irq` on the next edge. The same write with bit 0 equal to 0 has no effect. A violation in the same cycle as a clear wins.
- R10: A register write changes the check from the following cycle only. A request in the same cycle as the register write is judged against the old settings.
- R11: Read requests (`m_we` = 0) are always forwarded, whatever the window and mode.
- R12: After reset, legacy mode is off, both bounds are 0 and `viol_irq`, `viol_addr` and `viol_id` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 mode, 1 lower bound, 2 upper bound, 3 clear |
| cfg_wdata | input | ADDR_W | Register write data |
| m_req | input | 1 | Master request valid |
| m_we | input | 1 | Master request is a write |
| m_addr | input | ADDR_W | Master start address |
| m_len | input | LEN_W | Burst length minus one |
| m_id | input | ID_W | Issuing master ID |
| m_wdata | input | DATA_W | Master write data |
| m_grant | output | 1 | Request accepted (forwarded or refused) |
| mem_req | output | 1 | Memory-side request valid |
| mem_we | output | 1 | Memory-side write flag |
| mem_addr | output | ADDR_W | Memory-side address |
| mem_len | output | LEN_W | Memory-side burst length minus one |
| mem_id | output | ID_W | Memory-side master ID |
| mem_wdata | output | DATA_W | Memory-side write data |
| mem_rdy | input | 1 | Memory can accept a request |
| viol_irq | output | 1 | Sticky violation interrupt |
| viol_addr | output | ADDR_W | Start address of first refused write |
| viol_id | output | ID_W | Master ID of first refused write |

## Verification
The forwarding decision, the grant and the memory-side fields depend on the current inputs through logic alone, so they are due in the same cycle as the request. The bench drives each request just after a falling edge and samples these outputs 1 ns later, before the next rising edge. The interrupt, the captured address and ID, and any register write take effect on the rising edge after the stimulus. The bench reads them at the following falling edge. For the R10 case it also samples within the cycle of the register write itself, to confirm that the old settings are still in force.

// File: rtl/dwg_pkg.sv
package dwg_pkg;
    parameter int ADDR_W = 32;
    parameter int LEN_W  = 8;
    parameter int ID_W   = 3;
    parameter int DATA_W = 32;
    localparam int SEL_W = 2;
    localparam int END_W = ADDR_W + 1;

    typedef enum logic [SEL_W-1:0] {
        SEL_MODE  = 2'd0,
        SEL_LOWER = 2'd1,
        SEL_UPPER = 2'd2,
        SEL_CLEAR = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [ID_W-1:0]   id;
        logic [DATA_W-1:0] wdata;
    } xfer_t;

    typedef struct packed {
        logic              legacy;
        logic [ADDR_W-1:0] lower;
        logic [ADDR_W-1:0] upper;
    } window_t;

    // Last beat address, widened so a burst near the top cannot wrap.
    function automatic logic [END_W-1:0] burst_last(input logic [ADDR_W-1:0] a,
                                                    input logic [LEN_W-1:0] n);
        return {1'b0, a} + END_W'(n);
    endfunction

    // True when [a, a+n] intersects [lo, hi).
    function automatic logic burst_hits(input logic [ADDR_W-1:0] a,
                                        input logic [LEN_W-1:0] n,
                                        input logic [ADDR_W-1:0] lo,
                                        input logic [ADDR_W-1:0] hi);
        logic nonempty;
        logic below_top;
        logic reaches_base;
        nonempty     = lo < hi;
        below_top    = a < hi;
        reaches_base = burst_last(a, n) >= {1'b0, lo};
        return nonempty && below_top && reaches_base;
    endfunction
endpackage

// File: rtl/guard_cfg_regs.sv
module guard_cfg_regs
    import dwg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output window_t           win,
    output logic              clr_pulse
);
    window_t win_q;
    cfg_sel_e sel;

    assign sel = cfg_sel_e'(cfg_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
        end else if (cfg_we) begin
            unique case (sel)
                SEL_MODE:  win_q.legacy <= cfg_wdata[0];
                SEL_LOWER: win_q.lower  <= cfg_wdata;
                SEL_UPPER: win_q.upper  <= cfg_wdata;
                default:   win_q        <= win_q;
            endcase
        end
    end

    assign win       = win_q;
    assign clr_pulse = cfg_we && (sel == SEL_CLEAR) && cfg_wdata[0];
endmodule

// File: rtl/guard_write_path.sv
module guard_write_path
    import dwg_pkg::*;
(
    input  logic    m_req,
    input  xfer_t   m_xfer,
    input  logic    mem_rdy,
    input  window_t win,
    output logic    mem_req,
    output xfer_t   mem_xfer,
    output logic    m_grant,
    output logic    viol_fire
);
    logic hit;
    logic refuse;

    assign hit      = burst_hits(m_xfer.addr, m_xfer.len, win.lower, win.upper);
    assign refuse   = win.legacy && m_xfer.we && hit;

    assign mem_req   = m_req && !refuse;
    assign mem_xfer  = m_xfer;
    assign m_grant   = m_req && mem_rdy;
    assign viol_fire = m_req && mem_rdy && refuse;
endmodule

// File: rtl/guard_viol_log.sv
module guard_viol_log
    import dwg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              viol_fire,
    input  logic [ADDR_W-1:0] fire_addr,
    input  logic [ID_W-1:0]   fire_id,
    input  logic              clr_pulse,
    output logic              irq,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [ID_W-1:0]   cap_id
);
    logic              pend_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ID_W-1:0]   id_q;
    logic              load;

    // Capture only when nothing is pending or software clears in this cycle.
    assign load = viol_fire && (!pend_q || clr_pulse);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            addr_q <= '0;
            id_q   <= '0;
        end else begin
            if (load) begin
                addr_q <= fire_addr;
                id_q   <= fire_id;
            end
            if (viol_fire)
                pend_q <= 1'b1;
            else if (clr_pulse)
                pend_q <= 1'b0;
        end
    end

    assign irq      = pend_q;
    assign cap_addr = addr_q;
    assign cap_id   = id_q;
endmodule

// File: rtl/dma_window_guard.sv
module dma_window_guard
    import dwg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              m_req,
    input  logic              m_we,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [LEN_W-1:0]  m_len,
    input  logic [ID_W-1:0]   m_id,
    input  logic [DATA_W-1:0] m_wdata,
    output logic              m_grant,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LEN_W-1:0]  mem_len,
    output logic [ID_W-1:0]   mem_id,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rdy,
    output logic              viol_irq,
    output logic [ADDR_W-1:0] viol_addr,
    output logic [ID_W-1:0]   viol_id
);
    window_t win;
    logic    clr_pulse;
    logic    viol_fire;
    xfer_t   m_xfer;
    xfer_t   mem_xfer;

    assign m_xfer = '{we: m_we, addr: m_addr, len: m_len, id: m_id, wdata: m_wdata};

    guard_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .win       (win),
        .clr_pulse (clr_pulse)
    );

    guard_write_path u_path (
        .m_req     (m_req),
        .m_xfer    (m_xfer),
        .mem_rdy   (mem_rdy),
        .win       (win),
        .mem_req   (mem_req),
        .mem_xfer  (mem_xfer),
        .m_grant   (m_grant),
        .viol_fire (viol_fire)
    );

    guard_viol_log u_log (
        .clk       (clk),
        .rst       (rst),
        .viol_fire (viol_fire),
        .fire_addr (m_addr),
        .fire_id   (m_id),
        .clr_pulse (clr_pulse),
        .irq       (viol_irq),
        .cap_addr  (viol_addr),
        .cap_id    (viol_id)
    );

    assign mem_we    = mem_xfer.we;
    assign mem_addr  = mem_xfer.addr;
    assign mem_len   = mem_xfer.len;
    assign mem_id    = mem_xfer.id;
    assign mem_wdata = mem_xfer.wdata;
endmodule

// File: rtl/dma_window_guard_checker.sv
module dma_window_guard_checker
    import dwg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              m_req,
    input logic              m_we,
    input logic [ADDR_W-1:0] m_addr,
    input logic [LEN_W-1:0]  m_len,
    input logic              m_grant,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LEN_W-1:0]  mem_len,
    input logic              mem_rdy,
    input logic              viol_irq,
    input logic [ADDR_W-1:0] viol_addr,
    input logic              legacy,
    input logic [ADDR_W-1:0] win_lower,
    input logic [ADDR_W-1:0] win_upper,
    input logic              clr_pulse
);
    // R1
    mode_off_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (!legacy && m_req) |-> mem_req);

    // R11
    read_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (m_req && !m_we) |-> mem_req);

    // R4
    empty_window_chk: assert property (@(posedge clk) disable iff (rst)
        ((win_lower >= win_upper) && m_req) |-> mem_req);

    // R6
    forward_fields_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr == m_addr && mem_len == m_len));

    // R7
    refused_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (m_req && mem_rdy && !mem_req) |-> m_grant);

    // R8
    irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (m_req && m_we && mem_rdy && !mem_req) |=> viol_irq);

    // R8
    sticky_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (viol_irq && !clr_pulse) |=> (viol_irq && $stable(viol_addr)));

    // R9
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_pulse && !(m_req && m_we && mem_rdy && !mem_req)) |=> !viol_irq);
endmodule

bind dma_window_guard dma_window_guard_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .m_req     (m_req),
    .m_we      (m_we),
    .m_addr    (m_addr),
    .m_len     (m_len),
    .m_grant   (m_grant),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_len   (mem_len),
    .mem_rdy   (mem_rdy),
    .viol_irq  (viol_irq),
    .viol_addr (viol_addr),
    .legacy    (win.legacy),
    .win_lower (win.lower),
    .win_upper (win.upper),
    .clr_pulse (clr_pulse)
);

// File: tb/dma_window_guard_bench.sv
`timescale 1ns/1ps
module dma_window_guard_bench;
    import dwg_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [SEL_W-1:0]  cfg_sel = '0;
    logic [ADDR_W-1:0] cfg_wdata = '0;
    logic              m_req = 1'b0;
    logic              m_we = 1'b0;
    logic [ADDR_W-1:0] m_addr = '0;
    logic [LEN_W-1:0]  m_len = '0;
    logic [ID_W-1:0]   m_id = '0;
    logic [DATA_W-1:0] m_wdata = '0;
    logic              mem_rdy = 1'b1;
    logic              m_grant, mem_req, mem_we, viol_irq;
    logic [ADDR_W-1:0] mem_addr, viol_addr;
    logic [LEN_W-1:0]  mem_len;
    logic [ID_W-1:0]   mem_id, viol_id;
    logic [DATA_W-1:0] mem_wdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dma_window_guard u_dma_window_guard (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_len(m_len), .m_id(m_id),
        .m_wdata(m_wdata), .m_grant(m_grant), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_len(mem_len), .mem_id(mem_id), .mem_wdata(mem_wdata),
        .mem_rdy(mem_rdy), .viol_irq(viol_irq), .viol_addr(viol_addr), .viol_id(viol_id)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [SEL_W-1:0] s, input logic [ADDR_W-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive a request after a falling edge; combinational outputs are read 1 ns later.
    task automatic drive(input logic we, input logic [ADDR_W-1:0] a,
                         input logic [LEN_W-1:0] n, input logic [ID_W-1:0] id);
        @(negedge clk);
        m_req = 1'b1; m_we = we; m_addr = a; m_len = n; m_id = id;
        m_wdata = {a[15:0], 16'h5a5a};
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        m_req = 1'b0;
        #1;
    endtask

    task automatic set_window(input logic [ADDR_W-1:0] lo, input logic [ADDR_W-1:0] hi,
                              input logic mode);
        cfg(SEL_LOWER, lo);
        cfg(SEL_UPPER, hi);
        cfg(SEL_MODE, {{(ADDR_W-1){1'b0}}, mode});
    endtask

    task automatic t_reset();
        chk("R12 irq", viol_irq, 0);
        chk("R12 addr", viol_addr, 0);
        chk("R12 id", viol_id, 0);
        drive(1'b1, 32'h0, 8'd0, 3'd1);
        chk("R12 mode off at reset", mem_req, 1);
        idle();
    endtask

    task automatic t_mode_off();
        set_window(32'h1000, 32'h2000, 1'b0);
        drive(1'b1, 32'h1800, 8'd3, 3'd2);
        chk("R1 pass", mem_req, 1);
        chk("R6 addr", mem_addr, 32'h1800);
        chk("R6 len", mem_len, 3);
        chk("R6 id", mem_id, 2);
        chk("R6 we", mem_we, 1);
        chk("R6 data", mem_wdata, 32'h18005a5a);
        chk("R7 grant", m_grant, 1);
        idle();
        chk("R1 no irq", viol_irq, 0);
    endtask

    task automatic t_bounds();
        cfg(SEL_MODE, 32'h1);
        drive(1'b1, 32'h1000, 8'd0, 3'd1);
        chk("R3 lower inside", mem_req, 0);
        chk("R7 refused grant", m_grant, 1);
        drive(1'b1, 32'h1800, 8'd0, 3'd1);
        chk("R2 middle", mem_req, 0);
        drive(1'b1, 32'h1FFF, 8'd0, 3'd1);
        chk("R3 upper-1 inside", mem_req, 0);
        drive(1'b1, 32'h2000, 8'd0, 3'd1);
        chk("R3 upper outside", mem_req, 1);
        drive(1'b1, 32'h0FFF, 8'd0, 3'd1);
        chk("R3 below lower", mem_req, 1);
        idle();
    endtask

    task automatic t_burst();
        drive(1'b1, 32'h0FF0, 8'h0F, 3'd3);
        chk("R5 ends below", mem_req, 1);
        drive(1'b1, 32'h0FF0, 8'h10, 3'd3);
        chk("R5 touches lower", mem_req, 0);
        drive(1'b1, 32'h1FFE, 8'h05, 3'd3);
        chk("R5 starts inside", mem_req, 0);
        drive(1'b1, 32'h0F00, 8'hFF, 3'd3);
        chk("R5 ends at lower-1", mem_req, 1);
        drive(1'b1, 32'hFFFF_FFF0, 8'hFF, 3'd3);
        chk("R5 top no wrap", mem_req, 1);
        idle();
        set_window(32'h1000, 32'h1004, 1'b1);
        drive(1'b1, 32'h0FF8, 8'h20, 3'd3);
        chk("R5 spans window", mem_req, 0);
        idle();
        set_window(32'h1000, 32'h2000, 1'b1);
    endtask

    task automatic t_read();
        drive(1'b0, 32'h1800, 8'd7, 3'd4);
        chk("R11 read pass", mem_req, 1);
        chk("R11 we", mem_we, 0);
        idle();
    endtask

    task automatic t_irq();
        cfg(SEL_CLEAR, 32'h1);
        #1;
        chk("R9 cleared", viol_irq, 0);
        drive(1'b1, 32'h1234, 8'd0, 3'd5);
        idle();
        chk("R8 irq", viol_irq, 1);
        chk("R8 addr", viol_addr, 32'h1234);
        chk("R8 id", viol_id, 5);
        drive(1'b1, 32'h1500, 8'd0, 3'd2);
        idle();
        chk("R8 sticky addr", viol_addr, 32'h1234);
        chk("R8 sticky id", viol_id, 5);
        cfg(SEL_CLEAR, 32'h0);
        #1;
        chk("R9 zero ignored", viol_irq, 1);
        cfg(SEL_CLEAR, 32'h1);
        #1;
        chk("R9 clear", viol_irq, 0);
    endtask

    task automatic t_clear_collide();
        drive(1'b1, 32'h1100, 8'd0, 3'd1);
        idle();
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = SEL_CLEAR; cfg_wdata = 32'h1;
        m_req = 1'b1; m_we = 1'b1; m_addr = 32'h1700; m_len = 0; m_id = 3'd6;
        @(negedge clk);
        cfg_we = 1'b0; m_req = 1'b0;
        #1;
        chk("R9 fire wins irq", viol_irq, 1);
        chk("R9 fire wins addr", viol_addr, 32'h1700);
        chk("R9 fire wins id", viol_id, 6);
        cfg(SEL_CLEAR, 32'h1);
    endtask

    task automatic t_rdy_low();
        @(negedge clk);
        mem_rdy = 1'b0;
        drive(1'b1, 32'h1400, 8'd0, 3'd1);
        chk("R7 no grant without rdy", m_grant, 0);
        chk("R2 refused", mem_req, 0);
        idle();
        chk("R8 ungranted no irq", viol_irq, 0);
        mem_rdy = 1'b1;
    endtask

    task automatic t_empty();
        set_window(32'h3000, 32'h3000, 1'b1);
        drive(1'b1, 32'h3000, 8'd0, 3'd1);
        chk("R4 equal bounds", mem_req, 1);
        idle();
        set_window(32'h3000, 32'h2000, 1'b1);
        drive(1'b1, 32'h2800, 8'd0, 3'd1);
        chk("R4 inverted bounds", mem_req, 1);
        idle();
        chk("R4 no irq", viol_irq, 0);
    endtask

    task automatic t_timing();
        set_window(32'h1000, 32'h2000, 1'b1);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = SEL_MODE; cfg_wdata = 32'h0;
        m_req = 1'b1; m_we = 1'b1; m_addr = 32'h1800; m_len = 0; m_id = 3'd7;
        #1;
        chk("R10 old mode still", mem_req, 0);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        chk("R10 new mode", mem_req, 1);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = SEL_MODE; cfg_wdata = 32'h1;
        #1;
        chk("R10 old mode off", mem_req, 1);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        chk("R10 mode on next", mem_req, 0);
        idle();
        cfg(SEL_CLEAR, 32'h1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_mode_off();
        t_bounds();
        t_burst();
        t_read();
        t_irq();
        t_clear_collide();
        t_rdy_low();
        t_empty();
        t_timing();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule